// File: doc/BRIEF.md
# Serial Transmit Path with Holding Queue

This block is the sending half of a classic asynchronous serial channel. A host hands it bytes one at a time. Each byte waits in holding storage until the serializer is free, then leaves the chip as one character: a low start bit, five to eight data bits with the least significant first, an optional odd or even parity bit, and one or two high stop bits. With queue mode on, the holding storage is a 64-deep first-in first-out buffer. With queue mode off, it is a single byte register.

Timing comes from an oversample tick that a separate baud generator supplies. Each bit lasts 16 ticks, or 8 ticks when the fast oversample setting is chosen. The block reports two empty conditions. The first says the holding storage is empty. The second says that the holding storage is empty and the last character has fully left the line. A transmit-empty interrupt is built from the first condition.

Top module: `txq_serializer`

## Requirements
- R1: Out of reset, `txd` is 1, `thr_empty` is 1, `tsr_empty` is 1 and `tx_int` is 0. The line stays at 1 whenever `tsr_empty` is 1.
- R2: A character is sent as a start bit of 0, followed by the data bits least significant first. The number of data bits is 5 + `word_len` (00=5, 01=6, 10=7, 11=8).
- R3: When `par_en` is 1, one parity bit follows the data bits. With `par_even`=1 the parity bit makes the count of ones across the data and parity bits even. With `par_even`=0 it makes that count odd.
- R4: With `two_stop`=0 the stop bit lasts one bit time. With `two_stop`=1 the stop bits last two bit times, or 1.5 bit times when `word_len` is 00. The stop level is 1.
- R5: A bit time is 16 `os_tick` pulses when `os8x`=0 and 8 pulses when `os8x`=1. Cycles without a tick do not advance the character.
- R6: With `fifo_en`=1 the holding storage keeps up to 64 bytes. With `fifo_en`=0 it keeps one byte. A write that finds the holding storage full is dropped, and that byte is never sent.
- R7: `thr_empty` is 1 exactly when the holding storage is empty. It returns to 1 on the clock edge at which the last held byte moves into the serializer.
- R8: `tsr_empty` is 1 only when the holding storage is empty and no character is being shifted. It rises on the edge that ends the final stop bit.
- R9: A `fifo_clr` pulse, or any change of `fifo_en`, empties the holding storage on the next edge. The character already in the serializer still completes.
- R10: An interrupt request is latched when `thr_empty` goes from 0 to 1, or when `int_en` goes from 0 to 1 while `thr_empty` is 1. `tx_int` shows the latched request while `int_en` is 1. An `isr_rd` pulse clears the request, and so does any host write.
- R11: Word length, parity, stop and oversample settings are captured when a byte enters the serializer. Later changes to them do not affect that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One pulse per oversample period |
| wr_en | input | 1 | Host write strobe into holding storage |
| wr_data | input | 8 | Byte written by the host |
| fifo_en | input | 1 | 1 = 64-byte queue mode, 0 = single holding register |
| fifo_clr | input | 1 | Pulse that empties the holding storage |
| word_len | input | 2 | Data bits minus five |
| two_stop | input | 1 | Two stop bits (1.5 for 5-bit words) |
| par_en | input | 1 | Append parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| os8x | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| int_en | input | 1 | Transmit-empty interrupt enable |
| isr_rd | input | 1 | Interrupt status read that acknowledges the request |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding storage empty |
| tsr_empty | output | 1 | Holding storage and serializer both empty |
| tx_int | output | 1 | Transmit-empty interrupt |

## Verification
The checker watches, on every cycle, a set of invariants. The line is at mark level whenever the transmitter is empty, and the transmitter-empty flag never stands without the holding-empty flag. A flush always leaves the holding storage empty, and a write to full storage never raises the fill level. A host write always drops the interrupt, and the interrupt only rises while the holding storage is empty. Some behaviour cannot be seen from single cycles and needs the bench's scenarios. This covers the bit order and parity across whole characters, and the tick-exact length of a frame, including the 1.5-bit stop. It also covers the dropping of a byte written to full storage, which the bench observes as a missing character, and the capture of settings at load.

// File: rtl/txq_pkg.sv
// Package: shared types and helpers for the serial transmit path.
// Assumes: data bytes are 8 bits and word lengths run from 5 to 8.
package txq_pkg;

    // Serializer phase within one character.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // Character settings captured at load time.
    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       two_stop;
        logic       os8x;
    } frame_cfg_t;

    // Mask keeping the 5 + wlen low bits of a byte.
    function automatic logic [7:0] data_mask(input logic [1:0] wlen);
        return 8'hFF >> (3'd3 - {1'b0, wlen});
    endfunction

    // Parity bit for the masked data under the chosen sense.
    function automatic logic parity_of(input logic [7:0] d, input logic [1:0] wlen,
                                       input logic even);
        logic x;
        x = ^(d & data_mask(wlen));
        return even ? x : ~x;
    endfunction

endpackage

// File: rtl/txq_fifo.sv
// Module: holding storage for transmit bytes.
// Acts as a DEPTH-entry queue, or as a one-entry register when 'single' is 1.
// Assumes: flush has priority over push and pop. A push to full storage is dropped.
module txq_fifo #(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             wr_ok, rd_ok;

    // Fill limit depends on the selected mode.
    assign full  = single ? (count != '0) : (count == CW'(DEPTH));
    assign wr_ok = push & ~full & ~flush;
    assign rd_ok = pop & (count != '0) & ~flush;
    assign rdata = mem[rp];

    // Next pointer with explicit wrap for any depth.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= bump(wp);
            if (rd_ok) rp <= bump(rp);
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
        end
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

endmodule

// File: rtl/txq_shifter.sv
// Module: character serializer.
// Takes a byte when idle and one is available, then sends start, data (LSB first),
// optional parity and stop bits, each bit held for a tick-counted bit time.
// Assumes: tick is a single-cycle enable; settings are latched at load.
module txq_shifter
    import txq_pkg::*;
#(
    parameter  int OS_HI = 16,
    parameter  int OS_LO = 8,
    localparam int LW    = $clog2(2 * OS_HI + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       avail,
    input  logic [7:0] din,
    input  frame_cfg_t cfg,
    output logic       take,
    output logic       busy,
    output logic       txd
);

    phase_t        phase;
    frame_cfg_t    cfg_q;
    logic [LW-1:0] cnt, bit_len, limit;
    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic          par_q;
    logic          last_tick;

    assign take = (phase == PH_IDLE) & avail;
    assign busy = (phase != PH_IDLE);

    // Ticks in the current element; the stop element may be 1, 1.5 or 2 bit times.
    always_comb begin
        bit_len = cfg_q.os8x ? LW'(OS_LO) : LW'(OS_HI);
        limit   = bit_len;
        if (phase == PH_STOP && cfg_q.two_stop)
            limit = (cfg_q.wlen == 2'd0) ? bit_len + (bit_len >> 1) : bit_len << 1;
    end

    assign last_tick = tick & (cnt == limit - 1'b1);

    // Line level for each phase.
    always_comb begin
        unique case (phase)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = sh[0];
            PH_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    // Phase sequencing, tick counting and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sh    <= '0;
            bitn  <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (avail) begin
                phase <= PH_START;
                sh    <= din;
                cfg_q <= cfg;
                par_q <= parity_of(din, cfg.wlen, cfg.par_even);
            end
        end else if (tick) begin
            cnt <= last_tick ? '0 : cnt + 1'b1;
            if (last_tick) begin
                unique case (phase)
                    PH_START: begin
                        phase <= PH_DATA;
                        bitn  <= '0;
                    end
                    PH_DATA: begin
                        sh <= sh >> 1;
                        if (bitn == 3'd4 + {1'b0, cfg_q.wlen})
                            phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
                        else
                            bitn <= bitn + 1'b1;
                    end
                    PH_PAR:  phase <= PH_STOP;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/txq_serializer.sv
// Module: top of the serial transmit path.
// Joins the holding storage and the serializer, derives the two empty flags
// and keeps the transmit-empty interrupt request.
// Assumes: isr_rd is asserted only for a status read that reports this interrupt
// as the top pending source.
module txq_serializer
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_en,
    input  logic       fifo_clr,
    input  logic [1:0] word_len,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       os8x,
    input  logic       int_en,
    input  logic       isr_rd,
    output logic       txd,
    output logic       thr_empty,
    output logic       tsr_empty,
    output logic       tx_int
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [FILL_W-1:0] fill;
    logic [7:0]        head;
    logic              fifo_full, flush, take, busy;
    logic              fifo_en_q, thr_q, int_en_q, pend, set_req;
    frame_cfg_t        cfg;

    assign flush = fifo_clr | (fifo_en ^ fifo_en_q);
    assign cfg   = '{wlen: word_len, par_en: par_en, par_even: par_even,
                     two_stop: two_stop, os8x: os8x};

    txq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .single (~fifo_en),
        .push   (wr_en),
        .wdata  (wr_data),
        .pop    (take),
        .rdata  (head),
        .count  (fill),
        .full   (fifo_full)
    );

    txq_shifter #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .avail ((fill != '0) & ~flush),
        .din   (head),
        .cfg   (cfg),
        .take  (take),
        .busy  (busy),
        .txd   (txd)
    );

    assign thr_empty = (fill == '0);
    assign tsr_empty = thr_empty & ~busy;
    assign set_req   = (thr_empty & ~thr_q) | (int_en & ~int_en_q & thr_empty);
    assign tx_int    = pend & int_en;

    // Mode history, edge history and the interrupt request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
            thr_q     <= 1'b1;
            int_en_q  <= 1'b0;
            pend      <= 1'b0;
        end else begin
            fifo_en_q <= fifo_en;
            thr_q     <= thr_empty;
            int_en_q  <= int_en;
            if (wr_en && !flush) pend <= 1'b0;
            else if (set_req)    pend <= 1'b1;
            else if (isr_rd)     pend <= 1'b0;
        end
    end

endmodule

// File: rtl/txq_serializer_chk.sv
// Module: property checker for txq_serializer, attached with bind.
// Assumes: fill and full are the holding storage level and full flag.
module txq_serializer_chk #(
    parameter int FILL_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              thr_empty,
    input logic              tsr_empty,
    input logic              tx_int,
    input logic              wr_en,
    input logic              flush,
    input logic              full,
    input logic [FILL_W-1:0] fill
);

    // R1: an empty transmitter holds the line at mark.
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> txd);

    // R8: transmitter empty implies holding storage empty.
    p_tsr_needs_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_empty |-> thr_empty);

    // R6: a write to full storage never raises the fill level.
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> (fill <= $past(fill)));

    // R9: a flush leaves the holding storage empty.
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> thr_empty);

    // R10: a host write drops the interrupt.
    p_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> !tx_int);

    // R10: the interrupt only rises while holding storage is empty.
    p_int_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_int) |-> thr_empty);

endmodule

bind txq_serializer txq_serializer_chk #(.FILL_W(FILL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tsr_empty (tsr_empty),
    .tx_int    (tx_int),
    .wr_en     (wr_en),
    .flush     (flush),
    .full      (fifo_full),
    .fill      (fill)
);

// File: tb/test_txq_serializer.sv
module test_txq_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_en = 1'b0;
    logic       fifo_clr = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       os8x = 1'b0;
    logic       int_en = 1'b0;
    logic       isr_rd = 1'b0;
    logic       txd, thr_empty, tsr_empty, tx_int;

    int tests = 0;
    int fails = 0;
    int tick_mode = 2;   // 0 every cycle, 1 random one in three, 2 stalled

    always #5 clk = ~clk;

    txq_serializer i_txq_serializer (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .fifo_clr(fifo_clr), .word_len(word_len), .two_stop(two_stop),
        .par_en(par_en), .par_even(par_even), .os8x(os8x), .int_en(int_en),
        .isr_rd(isr_rd), .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .tx_int(tx_int)
    );

    // Tick source, updated away from the active edge.
    always @(negedge clk) begin
        case (tick_mode)
            0:       os_tick <= 1'b1;
            1:       os_tick <= ($urandom % 3) == 0;
            default: os_tick <= 1'b0;
        endcase
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected parity under the requirement R3 rule.
    function automatic logic exp_par(input logic [7:0] d, input int nb, input logic even);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        return even ? logic'(ones % 2) : logic'((ones % 2) == 0);
    endfunction

    // Expected line level of element b of a character.
    function automatic logic exp_bit(input logic [7:0] d, input int b, input int nb,
                                     input logic even);
        if (b == 0) return 1'b0;
        if (b <= nb) return d[b-1];
        return exp_par(d, nb, even);
    endfunction

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic pev,
                           input logic ts, input logic o8);
        word_len = wl; par_en = pe; par_even = pev; two_stop = ts; os8x = o8;
    endtask

    task automatic resume_ticks(input int mode);
        @(posedge clk);
        #1 tick_mode = mode;
    endtask

    // Follows one character on the line, sampling each bit in the middle of its time.
    task automatic grab_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                              input logic pev, input logic ts, input logic o8,
                              input bit last, input string req);
        int n = o8 ? 8 : 16;
        int nb = 5 + int'(wl);
        int nel = 1 + nb + (pe ? 1 : 0);
        int stop_t = ts ? ((wl == 2'd0) ? n + n / 2 : 2 * n) : n;
        int total = nel * n + stop_t;
        int ticks = 0;
        int b = 0;
        int guard = 0;
        bit stop_seen = 0;
        bit pre_seen = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (txd !== 1'b0 && guard < 60000);
        if (guard >= 60000) begin
            chk(1'b0, req, "start bit", int'(txd), 0);
            return;
        end
        while (ticks < total) begin
            @(posedge clk);
            if (os_tick) ticks++;
            @(negedge clk);
            if (b < nel && ticks == b * n + n / 2) begin
                chk(txd === exp_bit(d, b, nb, pev), req, $sformatf("bit %0d of %02h", b, d),
                    int'(txd), int'(exp_bit(d, b, nb, pev)));
                b++;
            end
            if (!stop_seen && ticks == nel * n + n / 2) begin
                stop_seen = 1;
                chk(txd === 1'b1, "R4", "stop level", int'(txd), 1);
            end
            if (last && !pre_seen && ticks == total - 1) begin
                pre_seen = 1;
                chk(tsr_empty === 1'b0, "R8", "busy before frame end", int'(tsr_empty), 0);
            end
        end
        if (last) chk(tsr_empty === 1'b1, "R8", "empty at frame end", int'(tsr_empty), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [1:0] wl;
        logic pe, pev, ts, o8;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(thr_empty === 1'b1, "R1", "thr_empty after reset", int'(thr_empty), 1);
        chk(tsr_empty === 1'b1, "R1", "tsr_empty after reset", int'(tsr_empty), 1);
        chk(tx_int === 1'b0, "R1", "tx_int after reset", int'(tx_int), 0);

        // R2 R5: directed 8 data bits, no parity, one stop bit, 16 ticks per bit
        set_cfg(2'd3, 0, 0, 0, 0);
        host_write(8'hA5);
        resume_ticks(0);
        grab_frame(8'hA5, 2'd3, 0, 0, 0, 0, 1, "R2");

        // R4 R5: 5 data bits with 1.5 stop bits, 8 ticks per bit
        set_cfg(2'd0, 1, 1, 1, 1);
        host_write(8'h1B);
        grab_frame(8'h1B, 2'd0, 1, 1, 1, 1, 1, "R4");

        // R2 R3 R4 R5: random settings, data and tick spacing
        tick_mode = 1;
        for (int k = 0; k < 8; k++) begin
            d = 8'($urandom); wl = 2'($urandom); pe = 1'($urandom);
            pev = 1'($urandom); ts = 1'($urandom); o8 = 1'($urandom);
            @(negedge clk);
            set_cfg(wl, pe, pev, ts, o8);
            host_write(d);
            grab_frame(d, wl, pe, pev, ts, o8, 1, "R3");
        end

        // R7: thr_empty timing around the move into the serializer
        resume_ticks(2);
        set_cfg(2'd2, 1, 0, 0, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h6C;
        @(negedge clk);
        wr_en = 1'b0;
        chk(thr_empty === 1'b0, "R7", "held after write", int'(thr_empty), 0);
        chk(tsr_empty === 1'b0, "R8", "not empty after write", int'(tsr_empty), 0);
        @(negedge clk);
        chk(thr_empty === 1'b1, "R7", "empty after load", int'(thr_empty), 1);
        chk(tsr_empty === 1'b0, "R8", "busy after load", int'(tsr_empty), 0);
        // R11: settings changed mid-character do not affect it
        set_cfg(2'd3, 0, 1, 1, 0);
        resume_ticks(0);
        grab_frame(8'h6C, 2'd2, 1, 0, 0, 1, 1, "R11");

        // R6: single-register mode drops a second write while occupied
        resume_ticks(2);
        set_cfg(2'd3, 0, 0, 0, 1);
        host_write(8'h11);
        host_write(8'h22);
        host_write(8'h33);
        chk(thr_empty === 1'b0, "R6", "holding full", int'(thr_empty), 0);
        resume_ticks(0);
        grab_frame(8'h11, 2'd3, 0, 0, 0, 1, 0, "R6");
        grab_frame(8'h22, 2'd3, 0, 0, 0, 1, 1, "R6");

        // R6: queue mode holds 64 bytes plus the one in the serializer
        resume_ticks(2);
        fifo_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 66; i++) host_write(8'(i * 3 + 1));
        chk(thr_empty === 1'b0, "R6", "queue holds data", int'(thr_empty), 0);
        resume_ticks(0);
        for (int i = 0; i < 65; i++)
            grab_frame(8'(i * 3 + 1), 2'd3, 0, 0, 0, 1, i == 64, "R6");

        // R9: clear pulse empties the queue, current character completes
        resume_ticks(2);
        for (int i = 0; i < 5; i++) host_write(8'hC0 + 8'(i));
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        chk(thr_empty === 1'b1, "R9", "empty after clear", int'(thr_empty), 1);
        chk(tsr_empty === 1'b0, "R9", "char kept after clear", int'(tsr_empty), 0);
        resume_ticks(0);
        grab_frame(8'hC0, 2'd3, 0, 0, 0, 1, 1, "R9");

        // R9: leaving queue mode also empties it
        resume_ticks(2);
        for (int i = 0; i < 3; i++) host_write(8'h5A + 8'(i));
        @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        chk(thr_empty === 1'b1, "R9", "empty after mode change", int'(thr_empty), 1);
        resume_ticks(0);
        grab_frame(8'h5A, 2'd3, 0, 0, 0, 1, 1, "R9");

        // R10: interrupt enable, acknowledge, write clear and re-arm
        resume_ticks(2);
        @(negedge clk);
        int_en = 1'b1;
        @(negedge clk);
        chk(tx_int === 1'b1, "R10", "raised on enable", int'(tx_int), 1);
        isr_rd = 1'b1;
        @(negedge clk);
        isr_rd = 1'b0;
        chk(tx_int === 1'b0, "R10", "cleared by status read", int'(tx_int), 0);
        host_write(8'h81);
        chk(tx_int === 1'b0, "R10", "low after write", int'(tx_int), 0);
        repeat (3) @(negedge clk);
        chk(tx_int === 1'b1, "R10", "raised after load", int'(tx_int), 1);
        host_write(8'h82);
        chk(tx_int === 1'b0, "R10", "cleared by write", int'(tx_int), 0);
        resume_ticks(0);
        grab_frame(8'h81, 2'd3, 0, 0, 0, 1, 0, "R10");
        grab_frame(8'h82, 2'd3, 0, 0, 0, 1, 1, "R10");
        chk(tx_int === 1'b1, "R10", "raised after drain", int'(tx_int), 1);
        @(negedge clk);
        int_en = 1'b0;
        @(negedge clk);
        chk(tx_int === 1'b0, "R10", "masked when disabled", int'(tx_int), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule